// File: doc/BRIEF.md
# Even/Odd Split 8-Point DCT Engine

This block turns a block of eight signed samples into its eight discrete cosine transform coefficients. A butterfly stage first forms the four mirrored sums x[m] + x[7-m] and the four mirrored differences x[m] - x[7-m], for m = 0..3. Coefficients with an even index depend only on the sums. Those with an odd index depend only on the differences. Each coefficient is therefore a four-term inner product. A single bit-serial distributed-arithmetic core computes all eight of them in turn. It walks the nine two's-complement bit slices of the operands, most significant first, and sums words read from one shared table.

The table holds sixteen words for each coefficient index, 128 words in all, at address {k, slice bits}. Its contents are computed from the cosine basis when the design is elaborated. A different transform needs only different table contents. The datapath does not change.

Samples enter through a valid/ready handshake. A block is accepted when in_valid and in_ready are both high at a rising edge, and in_ready stays low until the block's last coefficient has been formed. Coefficients leave in index order through a valid/ready output. While out_valid is high and out_ready is low, the coefficient and its index hold steady, and the core stalls before it overwrites them. Nothing is dropped under back-pressure.

Top module: `eo_dct8`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready falls in the cycle after a block is accepted. It stays 0 until the block's last coefficient has been loaded into the output register, and then returns to 1.
- R3: Each accepted block yields exactly eight coefficients, with out_idx counting 0, 1, ..., 7 in order.
- R4: Let y_k = (c_k / 4) * sum over m of x[m] * cos((2m+1)*k*pi/16), with c_0 = 1/sqrt(2) and c_k = 1 otherwise. Sample m is in_samples[8m+7:8m], signed. Coefficient k equals y_k rounded to nearest and clipped to a signed 8-bit value, within 1 LSB.
- R5: A block of eight equal samples gives a nonzero coefficient 0 and zero for every other index (within 1 LSB).
- R6: Results outside [-128, 127] saturate. Eight samples of 127 give coefficient 0 = 127 exactly. Eight samples of -128 give -128. Four samples of 127 followed by four of -128 give coefficient 1 = 127.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_coef and out_idx do not change. Coefficients delivered under random back-pressure match those delivered with no back-pressure.
- R8: A mirror-symmetric block (x[m] = x[7-m]) gives odd coefficients of exactly 0. A mirror-antisymmetric block gives even coefficients of exactly 0.
- R9: in_samples is sampled only at acceptance. Changing it while the block is being processed has no effect on that block's results.
- R10: With out_ready held at 1, coefficient k is first presented 11*(k+1) cycles after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An input block is offered |
| in_ready | output | 1 | The engine is idle and will take a block |
| in_samples | input | 64 | Eight signed 8-bit samples; sample m is at bits [8m+7:8m] |
| out_valid | output | 1 | out_coef and out_idx hold a coefficient |
| out_ready | input | 1 | The consumer takes the coefficient |
| out_coef | output | 8 | Signed, rounded, saturated coefficient |
| out_idx | output | 3 | Index k of out_coef |

## Verification
Some properties are checked on every cycle. The output holds steady under back-pressure, the index follows its 0..7 succession, in_ready drops after acceptance, and the shifting accumulator never loses its top bit. The bench scenarios cover what a single-cycle property cannot show. These are the numerical agreement with a real-valued cosine reference, exact zeros for symmetric and antisymmetric blocks, exact saturation values, immunity to input changes after acceptance, and the 11-cycle coefficient cadence.

// File: rtl/eo_dct_pkg.sv
package eo_dct_pkg;

  localparam int NPT  = 8;
  localparam int HALF = NPT / 2;
  localparam int KW   = 3;

  // cos(j*pi/16) scaled by 2^15, j = 0..8
  localparam int COS_Q15 [9] = '{32768, 32138, 30273, 27246, 23170, 18205, 12540, 6393, 0};

  function automatic int cos_q15(input int j);
    int r;
    r = j % 32;
    if (r > 16) r = 32 - r;
    if (r > 8) return -COS_Q15[16 - r];
    return COS_Q15[r];
  endfunction

  // weight of operand m for coefficient k, rounded symmetrically
  function automatic int da_weight(input int k, input int m, input int shift);
    int v;
    v = (k == 0) ? COS_Q15[4] : cos_q15((2 * m + 1) * k);
    if (v >= 0) return (v + (1 << (shift - 1))) >>> shift;
    return -((-v + (1 << (shift - 1))) >>> shift);
  endfunction

  // table word: sum of weights whose operand bit is set
  function automatic int da_entry(input int k, input int sel, input int shift);
    int s;
    s = 0;
    for (int m = 0; m < HALF; m++)
      if (((sel >> m) & 1) == 1) s += da_weight(k, m, shift);
    return s;
  endfunction

endpackage

// File: rtl/eo_dct_frontend.sv
module eo_dct_frontend
  import eo_dct_pkg::*;
#(
  parameter int DW = 8,
  parameter int UW = DW + 1,
  parameter int BW = $clog2(UW)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NPT*DW-1:0]   samples,
  input  logic                odd_sel,
  input  logic [BW-1:0]       bsel,
  output logic [HALF-1:0]     slice
);

  logic signed [UW-1:0] sum_q [HALF];
  logic signed [UW-1:0] dif_q [HALF];

  for (genvar m = 0; m < HALF; m++) begin : g_fly
    logic signed [UW-1:0] lo_x, hi_x;
    assign lo_x = UW'($signed(samples[m*DW +: DW]));
    assign hi_x = UW'($signed(samples[(NPT-1-m)*DW +: DW]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q[m] <= '0;
        dif_q[m] <= '0;
      end else if (load) begin
        sum_q[m] <= lo_x + hi_x;
        dif_q[m] <= lo_x - hi_x;
      end
    end

    assign slice[m] = odd_sel ? dif_q[m][bsel] : sum_q[m][bsel];
  end

endmodule

// File: rtl/eo_dct_coef_rom.sv
module eo_dct_coef_rom
  import eo_dct_pkg::*;
#(
  parameter int RW  = 14,
  parameter int WSH = 5,
  localparam int AB = KW + HALF,
  localparam int DEPTH = 1 << AB
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 rd_first,
  input  logic [AB-1:0]        addr,
  output logic signed [RW-1:0] data_q,
  output logic                 vld_q,
  output logic                 first_q
);

  logic signed [RW-1:0] tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
    assign tbl[gi] = RW'(da_entry(gi / (1 << HALF), gi % (1 << HALF), WSH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      vld_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      vld_q   <= rd_en;
      first_q <= rd_en & rd_first;
      if (rd_en) data_q <= tbl[addr];
    end
  end

endmodule

// File: rtl/eo_dct_accum.sv
module eo_dct_accum #(
  parameter int RW = 14,
  parameter int AW = 24,
  parameter int CF = 12,
  parameter int OW = 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic                 first,
  input  logic signed [RW-1:0] data,
  output logic signed [OW-1:0] result
);

  localparam logic signed [AW-1:0] RHALF = {{(AW-CF){1'b0}}, 1'b1, {(CF-1){1'b0}}};
  localparam logic signed [AW-1:0] OMAX  = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN  = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [AW-1:0] acc, dext, rnd;

  assign dext = {{(AW-RW){data[RW-1]}}, data};

  // most significant slice (sign) arrives first and is subtracted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (vld) begin
      if (first)    acc <= -dext;
      else          acc <= (acc <<< 1) + dext;
    end
  end

  assign rnd = (acc + RHALF) >>> CF;

  always_comb begin
    if (rnd > OMAX)      result = OMAX[OW-1:0];
    else if (rnd < OMIN) result = OMIN[OW-1:0];
    else                 result = rnd[OW-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !first) |-> (acc[AW-1] == acc[AW-2])); // R4

endmodule

// File: rtl/eo_dct_seq.sv
module eo_dct_seq
  import eo_dct_pkg::*;
#(
  parameter int UW = 9,
  parameter int BW = $clog2(UW)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          load,
  output logic          rd_en,
  output logic          rd_first,
  output logic [KW-1:0] k_q,
  output logic [BW-1:0] b_q,
  input  logic          out_free,
  output logic          emit
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_EMIT} st_t;
  st_t st;

  localparam logic [BW-1:0] BTOP = BW'(UW - 1);
  localparam logic [KW-1:0] KLAST = KW'(NPT - 1);

  assign in_ready = (st == S_IDLE);
  assign load     = in_ready & in_valid;
  assign rd_en    = (st == S_RUN);
  assign rd_first = (b_q == BTOP);
  assign emit     = (st == S_EMIT) & out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      k_q <= '0;
      b_q <= BTOP;
    end else begin
      unique case (st)
        S_IDLE: if (in_valid) begin
          st  <= S_RUN;
          k_q <= '0;
          b_q <= BTOP;
        end
        S_RUN: begin
          if (b_q == '0) st <= S_DRAIN;
          else           b_q <= b_q - 1'b1;
        end
        S_DRAIN: st <= S_EMIT;
        S_EMIT: if (out_free) begin
          b_q <= BTOP;
          if (k_q == KLAST) st <= S_IDLE;
          else begin
            k_q <= k_q + 1'b1;
            st  <= S_RUN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

endmodule

// File: rtl/eo_dct8.sv
module eo_dct8
  import eo_dct_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OW  = 8,
  parameter int CF  = 12,
  parameter int OSH = 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NPT*DW-1:0]    in_samples,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_coef,
  output logic [KW-1:0]        out_idx
);

  localparam int UW  = DW + 1;
  localparam int BW  = $clog2(UW);
  localparam int RW  = CF - OSH + 4;
  localparam int AW  = RW + UW + 1;
  localparam int WSH = 15 - CF + OSH;

  logic          load, rd_en, rd_first, emit, out_free;
  logic [KW-1:0] k_q;
  logic [BW-1:0] b_q;
  logic [HALF-1:0] slice;
  logic signed [RW-1:0] rom_q;
  logic rom_vld, rom_first;
  logic signed [OW-1:0] result;

  eo_dct_seq #(.UW(UW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .rd_en(rd_en), .rd_first(rd_first), .k_q(k_q), .b_q(b_q),
    .out_free(out_free), .emit(emit)
  );

  eo_dct_frontend #(.DW(DW), .UW(UW), .BW(BW)) u_fe (
    .clk(clk), .rst_n(rst_n), .load(load), .samples(in_samples),
    .odd_sel(k_q[0]), .bsel(b_q), .slice(slice)
  );

  eo_dct_coef_rom #(.RW(RW), .WSH(WSH)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_first(rd_first),
    .addr({k_q, slice}), .data_q(rom_q), .vld_q(rom_vld), .first_q(rom_first)
  );

  eo_dct_accum #(.RW(RW), .AW(AW), .CF(CF), .OW(OW)) u_acc (
    .clk(clk), .rst_n(rst_n), .vld(rom_vld), .first(rom_first),
    .data(rom_q), .result(result)
  );

  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_coef  <= '0;
      out_idx   <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_coef  <= result;
      out_idx   <= k_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // expected next index, advanced on each delivered coefficient
  logic [KW-1:0] exp_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_idx <= '0;
    else if (out_valid && out_ready) exp_idx <= out_idx + 1'b1;
  end

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_idx))); // R7

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == exp_idx)); // R3

endmodule

// File: tb/tb_eo_dct8.sv
module tb_eo_dct8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_samples = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [7:0] out_coef;
  logic [2:0] out_idx;

  int n_chk = 0, n_bad = 0;
  int got [8];
  int gidx [8];
  int gcyc [8];
  int ncoll;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eo_dct8 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_idx(out_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_coef(input int k, input int xs[8]);
    real s, v;
    int r;
    s = 0.0;
    for (int m = 0; m < 8; m++)
      s += xs[m] * $cos((2 * m + 1) * k * 3.14159265358979 / 16.0);
    if (k == 0) s = s / $sqrt(2.0);
    v = s / 4.0;
    r = int'($floor(v + 0.5));
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic run_block(input int xs[8], input bit bp, input bit scramble);
    bit rdy;
    int cyc, guard;
    bit busy_bad;
    @(negedge clk);
    for (int m = 0; m < 8; m++) in_samples[m*8 +: 8] = xs[m][7:0];
    in_valid = 1'b1;
    guard = 0;
    do begin
      rdy = in_ready;
      @(negedge clk);
      guard++;
    end while (!rdy && guard < 2000);
    in_valid = 1'b0;
    if (scramble) in_samples = {$urandom, $urandom};
    cyc = 1; ncoll = 0; busy_bad = 0;
    while (ncoll < 8 && cyc < 3000) begin
      out_ready = bp ? 1'($urandom % 2) : 1'b1;
      if (in_ready && ncoll < 7) busy_bad = 1;
      if (out_valid && out_ready) begin
        got[ncoll] = out_coef;
        gidx[ncoll] = out_idx;
        gcyc[ncoll] = cyc;
        ncoll++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    check(ncoll == 8, "R3 coefficient count", ncoll, 8);
    for (int i = 0; i < 8; i++) check(gidx[i] == i, "R3 index order", gidx[i], i);
    check(!busy_bad, "R2 in_ready low while busy", busy_bad, 0);
    check(in_ready == 1'b1, "R2 in_ready back after block", in_ready, 1);
  endtask

  task automatic cmp_all(input int xs[8], input string req);
    for (int k = 0; k < 8; k++) begin
      int e;
      e = ref_coef(k, xs);
      check(got[k] >= e - 1 && got[k] <= e + 1, req, got[k], e);
    end
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_dc_latency();
    int xs[8] = '{40, 40, 40, 40, 40, 40, 40, 40};
    run_block(xs, 0, 0);
    check(got[0] >= 56 && got[0] <= 58, "R5 dc term", got[0], 57);
    for (int k = 1; k < 8; k++) check(got[k] >= -1 && got[k] <= 1, "R5 ac terms zero", got[k], 0);
    for (int k = 0; k < 8; k++) check(gcyc[k] == 11 * (k + 1) + 1, "R10 coefficient timing", gcyc[k], 11 * (k + 1) + 1);
  endtask

  task automatic t_symmetry();
    int s[8] = '{10, -20, 30, -40, -40, 30, -20, 10};
    int a[8] = '{50, -25, 12, 100, -100, -12, 25, -50};
    run_block(s, 0, 0);
    for (int k = 1; k < 8; k += 2) check(got[k] == 0, "R8 odd zero on symmetric", got[k], 0);
    cmp_all(s, "R4 symmetric block");
    run_block(a, 0, 0);
    for (int k = 0; k < 8; k += 2) check(got[k] == 0, "R8 even zero on antisymmetric", got[k], 0);
    cmp_all(a, "R4 antisymmetric block");
  endtask

  task automatic t_saturate();
    int p[8] = '{127, 127, 127, 127, 127, 127, 127, 127};
    int q[8] = '{-128, -128, -128, -128, -128, -128, -128, -128};
    int h[8] = '{127, 127, 127, 127, -128, -128, -128, -128};
    run_block(p, 0, 0);
    check(got[0] == 127, "R6 positive clip", got[0], 127);
    run_block(q, 0, 0);
    check(got[0] == -128, "R6 negative clip", got[0], -128);
    run_block(h, 0, 0);
    check(got[1] == 127, "R6 clip on k=1", got[1], 127);
    cmp_all(h, "R4 step block");
  endtask

  task automatic t_random();
    for (int t = 0; t < 4; t++) begin
      int xs[8];
      for (int m = 0; m < 8; m++) xs[m] = int'($signed(8'($urandom)));
      run_block(xs, 0, 0);
      cmp_all(xs, "R4 random block");
    end
  endtask

  task automatic t_backpressure();
    int xs[8] = '{-77, 3, 90, -12, 45, -100, 6, 33};
    int ref_got[8];
    run_block(xs, 0, 0);
    for (int k = 0; k < 8; k++) ref_got[k] = got[k];
    run_block(xs, 1, 0);
    for (int k = 0; k < 8; k++) check(got[k] == ref_got[k], "R7 same result under back-pressure", got[k], ref_got[k]);
  endtask

  task automatic t_input_change();
    int xs[8] = '{17, -64, 120, -3, 8, 55, -90, 101};
    for (int r = 0; r < 2; r++) begin
      run_block(xs, 0, 1);
      cmp_all(xs, "R9 input changed after accept");
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dc_latency();
    t_symmetry();
    t_saturate();
    t_random();
    t_backpressure();
    t_input_change();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule